// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This controller sits on the host side of a 12-bit successive-approximation converter that has a serial output. It runs one full sample cycle for each start request. First it pulls the active-low convert-start line low for a set time and then releases it, which makes the converter hold its input and begin converting. Next it waits out the conversion time. It then toggles a serial clock sixteen times and shifts in one bit on each falling edge of that clock.

A frame holds four pad bits followed by twelve data bits, most significant bit first. The controller drops the pad bits and presents the twelve data bits as the result, together with a one-cycle valid strobe. A parameter chooses the coding. In two's-complement mode the result can be sign-extended to the output width. In straight-binary mode it is always zero-extended. If any pad bit arrives as a one, the controller raises a frame-error flag with the strobe.

All timing is set in system clock cycles through parameters. Each default is the stated minimum at a 4 ns clock, rounded up. Between the end of one frame and the next hold edge, the controller leaves the converter's acquisition gap.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, convert-start is high, the serial clock is low, and busy, valid, frame error and the result are all zero.
- R2: A start request seen while idle begins one cycle. Busy is high from the next cycle until the cycle in which the strobe rises, and falls in that cycle. Start requests seen while busy are ignored: the cycle gives exactly one convert-start pulse and one strobe, and no later cycle is queued.
- R3: When the acquisition gap has already elapsed, convert-start stays low for exactly CNV_LOW_CYC cycles. Otherwise it stays low for longer.
- R4: The first serial clock rising edge comes at least CONV_WAIT_CYC cycles after convert-start rises.
- R5: Each frame has exactly 16 serial clock pulses. Each high phase is at least SCK_HI_CYC cycles and each low phase between pulses is at least SCK_LO_CYC cycles. The serial clock is low whenever the block is idle, including at the end of each frame.
- R6: The data line is sampled on the system clock edge that drives the serial clock low. The first 4 bits are pad bits. The next 12 bits, first received being bit 11, form the result.
- R7: With SIGNED_CODE=1 and SIGN_EXT=1, result bits 15..12 copy data bit 11. With SIGNED_CODE=0, result bits 15..12 are zero.
- R8: The frame-error flag is set with the strobe if any pad bit was one and cleared otherwise. The data bits are returned either way.
- R9: At least ACQ_CYC cycles pass between the last serial clock falling edge of a frame and the next convert-start rising edge.
- R10: The valid strobe lasts exactly one cycle. The result and the flag hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion and readout |
| sdata_i | input | 1 | Serial data from the converter |
| convst_n_o | output | 1 | Active-low convert-start to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | A cycle is in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | OUT_W | Extended 12-bit sample |
| frame_err_o | output | 1 | A pad bit was read as one |

## Verification
The converter model is fed all-zero and all-one samples and the two codes on either side of mid-scale (0x800 and 0x7FF). These separate a dropped or doubled bit, a bit-order reversal, and correct sign extension from plain zero fill. Two instances run side by side, one in each coding, so the same code must give different upper bits. Single pad-bit errors at each end of the pad field show whether the pad window is aligned to the frame. A clean frame run after them shows that the flag clears. A start request held during a cycle and a request issued on the strobe cycle itself separate ignoring a request from queuing it, and check that a back-to-back start still leaves the acquisition gap.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV_LOW,
        ST_CONV,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_FIN
    } rd_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clr_i)
            word_d = '0;
        else if (en_i)
            word_d = {word_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/adc_rd_format.sv
module adc_rd_format #(
    parameter int DATA_W      = 12,
    parameter int OUT_W       = 16,
    parameter int SIGNED_CODE = 1,
    parameter int SIGN_EXT    = 1
) (
    input  logic [DATA_W-1:0] raw_i,
    output logic [OUT_W-1:0]  out_o
);
    localparam int EXT_W = OUT_W - DATA_W;

    generate
        if (EXT_W <= 0) begin : g_plain
            assign out_o = raw_i[OUT_W-1:0];
        end else if ((SIGNED_CODE != 0) && (SIGN_EXT != 0)) begin : g_sext
            assign out_o = {{EXT_W{raw_i[DATA_W-1]}}, raw_i};
        end else begin : g_zext
            assign out_o = {{EXT_W{1'b0}}, raw_i};
        end
    endgenerate
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
    parameter int DATA_W        = 12,
    parameter int PAD_W         = 4,
    parameter int OUT_W         = 16,
    parameter int SIGNED_CODE   = 1,
    parameter int SIGN_EXT      = 1,
    parameter int CNV_LOW_CYC   = 13,
    parameter int CONV_WAIT_CYC = 1500,
    parameter int SCK_HI_CYC    = 15,
    parameter int SCK_LO_CYC    = 8,
    parameter int ACQ_CYC       = 375
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sdata_i,
    output logic             convst_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] result_o,
    output logic             frame_err_o
);
    import adc_rd_pkg::*;

    localparam int FRAME_W = DATA_W + PAD_W;
    localparam int BIT_W   = $clog2(FRAME_W + 1);
    localparam int MAX_CYC = imax(imax(CNV_LOW_CYC, CONV_WAIT_CYC), imax(SCK_HI_CYC, SCK_LO_CYC));
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam int ACQ_W   = $clog2(ACQ_CYC + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        rd_state_e        st;
        logic             convst_n;
        logic             sclk;
        logic             busy;
        logic             valid;
        logic             err;
        logic [BIT_W-1:0] bits;
        logic [OUT_W-1:0] res;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             acq_load, acq_zero;
    logic             sh_clr, sh_en;
    logic [FRAME_W-1:0] frame_w;
    logic [OUT_W-1:0]   fmt_w;

    adc_rd_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    adc_rd_timer #(.W(ACQ_W)) u_acq (
        .clk(clk), .rst_n(rst_n), .load_i(acq_load), .val_i(ACQ_W'(ACQ_CYC)), .zero_o(acq_zero)
    );

    adc_rd_shift #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr_i(sh_clr), .en_i(sh_en), .bit_i(sdata_i), .word_o(frame_w)
    );

    adc_rd_format #(
        .DATA_W(DATA_W), .OUT_W(OUT_W), .SIGNED_CODE(SIGNED_CODE), .SIGN_EXT(SIGN_EXT)
    ) u_fmt (
        .raw_i(frame_w[DATA_W-1:0]), .out_o(fmt_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        acq_load = 1'b0;
        sh_clr   = 1'b0;
        sh_en    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st       = ST_CNV_LOW;
                    r_d.convst_n = 1'b0;
                    r_d.busy     = 1'b1;
                    r_d.bits     = '0;
                    tmr_load     = 1'b1;
                    tmr_val      = TMR_W'(CNV_LOW_CYC - 1);
                    sh_clr       = 1'b1;
                end
            end
            ST_CNV_LOW: begin
                if (tmr_zero && acq_zero) begin
                    r_d.st       = ST_CONV;
                    r_d.convst_n = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = TMR_W'(CONV_WAIT_CYC - 1);
                end
            end
            ST_CONV: begin
                if (tmr_zero) begin
                    r_d.st   = ST_SCK_HI;
                    r_d.sclk = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SCK_HI_CYC - 1);
                end
            end
            ST_SCK_HI: begin
                if (tmr_zero) begin
                    r_d.sclk = 1'b0;
                    sh_en    = 1'b1;
                    r_d.bits = r_q.bits + 1'b1;
                    if (r_q.bits == LAST_BIT) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st   = ST_SCK_LO;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(SCK_LO_CYC - 1);
                    end
                end
            end
            ST_SCK_LO: begin
                if (tmr_zero) begin
                    r_d.st   = ST_SCK_HI;
                    r_d.sclk = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SCK_HI_CYC - 1);
                end
            end
            ST_FIN: begin
                r_d.res   = fmt_w;
                r_d.err   = |frame_w[FRAME_W-1:DATA_W];
                r_d.valid = 1'b1;
                r_d.busy  = 1'b0;
                r_d.st    = ST_IDLE;
                acq_load  = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, convst_n: 1'b1, sclk: 1'b0, busy: 1'b0,
                     valid: 1'b0, err: 1'b0, bits: '0, res: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign convst_n_o  = r_q.convst_n;
    assign sclk_o      = r_q.sclk;
    assign busy_o      = r_q.busy;
    assign valid_o     = r_q.valid;
    assign result_o    = r_q.res;
    assign frame_err_o = r_q.err;

    // ---------------- checks on the port timing ----------------
    logic [31:0] chk_low_run, chk_since_rise, chk_since_fall;
    logic [4:0]  chk_falls;
    logic        chk_sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_low_run    <= '0;
            chk_since_rise <= '0;
            chk_since_fall <= '1;
            chk_falls      <= '0;
            chk_sclk_prev  <= 1'b0;
        end else begin
            chk_sclk_prev <= r_q.sclk;
            chk_low_run   <= r_q.convst_n ? '0 : chk_low_run + 1'b1;
            if (!r_q.convst_n)
                chk_since_rise <= '0;
            else if (chk_since_rise != '1)
                chk_since_rise <= chk_since_rise + 1'b1;
            if (chk_sclk_prev && !r_q.sclk)
                chk_since_fall <= '0;
            else if (chk_since_fall != '1)
                chk_since_fall <= chk_since_fall + 1'b1;
            if (!r_q.convst_n)
                chk_falls <= '0;
            else if (chk_sclk_prev && !r_q.sclk)
                chk_falls <= chk_falls + 1'b1;
        end
    end

    a_r3_convst_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_n_o) |-> chk_low_run >= 32'(CNV_LOW_CYC));

    a_r4_conversion_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> chk_since_rise >= 32'(CONV_WAIT_CYC));

    a_r5_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    a_r5_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> chk_falls == 5'(FRAME_W));

    a_r2_busy_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(busy_o) && !busy_o));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r9_acquisition_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_n_o) |-> chk_since_fall >= 32'(ACQ_CYC));

endmodule

// File: tb/adc_serial_reader_test.sv
module adc_frame_model #(
    parameter int DATA_W = 12,
    parameter int PAD_W  = 4
) (
    input  logic              convst_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample,
    input  logic [PAD_W-1:0]  pad,
    output logic              sdata
);
    localparam int FW = DATA_W + PAD_W;
    logic [FW-1:0] frame;
    int   cnt;
    logic oe, bitv;

    initial begin
        frame = '0; cnt = FW; oe = 1'b0; bitv = 1'b0;
    end

    always @(negedge convst_n) begin cnt = 0; oe = 1'b0; end
    always @(posedge convst_n) frame = {pad, sample};
    always @(posedge sclk) begin
        if (cnt < FW) begin
            bitv = frame[FW-1-cnt];
            oe   = 1'b1;
            cnt  = cnt + 1;
        end
    end
    always @(negedge sclk) if (cnt >= FW) oe = 1'b0;

    assign sdata = oe ? bitv : 1'b1;
endmodule

module adc_serial_reader_test;
    localparam int CNV_LOW = 13, CONV_WAIT = 1500, SCK_HI = 15, SCK_LO = 8, ACQ = 375;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [11:0] smp = '0;
    logic [3:0]  pad_v = '0;
    logic sd_s, sd_u, cv_s, cv_u, sk_s, sk_u, busy_s, busy_u, val_s, val_u, err_s, err_u;
    logic [15:0] res_s, res_u;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_serial_reader #(.SIGNED_CODE(1), .SIGN_EXT(1)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sdata_i(sd_s), .convst_n_o(cv_s),
        .sclk_o(sk_s), .busy_o(busy_s), .valid_o(val_s), .result_o(res_s), .frame_err_o(err_s));
    adc_serial_reader #(.SIGNED_CODE(0), .SIGN_EXT(1)) uut_u (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sdata_i(sd_u), .convst_n_o(cv_u),
        .sclk_o(sk_u), .busy_o(busy_u), .valid_o(val_u), .result_o(res_u), .frame_err_o(err_u));
    adc_frame_model m_s (.convst_n(cv_s), .sclk(sk_s), .sample(smp), .pad(pad_v), .sdata(sd_s));
    adc_frame_model m_u (.convst_n(cv_u), .sclk(sk_u), .sample(smp), .pad(pad_v), .sdata(sd_u));

    // port monitor, sampled between edges
    logic prev_cv = 1'b1, prev_sk = 1'b0;
    bit   seen_rise = 1'b0;
    int low_run = 0, last_low = 0, since_rise = 0, last_wait = 0;
    int hi_run = 0, lo_run = 0, min_hi = 0, min_lo = 0, falls = 0;
    int since_fall = 1000000, last_gap = 0, n_cv_fall = 0, n_valid = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sk_s && !prev_sk) begin
                if (!seen_rise) last_wait = since_rise;
                else if (lo_run < min_lo) min_lo = lo_run;
                seen_rise = 1'b1;
                hi_run = 1;
            end else if (sk_s) hi_run++;
            if (!sk_s && prev_sk) begin
                if (hi_run < min_hi) min_hi = hi_run;
                falls++;
                lo_run = 1;
                since_fall = 0;
            end else begin
                if (!sk_s) lo_run++;
                since_fall++;
            end
            if (prev_cv && !cv_s) begin
                n_cv_fall++; low_run = 1; falls = 0; seen_rise = 1'b0;
                min_hi = 1000000; min_lo = 1000000;
            end else if (!cv_s) low_run++;
            if (!prev_cv && cv_s) begin
                last_low = low_run; last_gap = since_fall; since_rise = 1;
            end else if (cv_s) since_rise++;
            if (val_s) n_valid++;
            prev_cv = cv_s;
            prev_sk = sk_s;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 6000; i++) begin
            if (val_s) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic check_result(input logic [11:0] s, input logic [3:0] p);
        logic [15:0] exp_s, exp_u;
        exp_s = {{4{s[11]}}, s};
        exp_u = {4'b0000, s};
        check(val_s === 1'b1, "R2", "strobe seen", int'(val_s), 1);
        check(res_s === exp_s, "R6", "two's complement result", int'(res_s), int'(exp_s));
        check(res_u === exp_u, "R7", "straight binary result", int'(res_u), int'(exp_u));
        check(err_s === (p != 0), "R8", "frame error flag", int'(err_s), int'(p != 0));
        check(busy_s === 1'b0, "R2", "busy low at strobe", int'(busy_s), 0);
        check(sk_s === 1'b0, "R5", "sclk low at frame end", int'(sk_s), 0);
        check(falls == 16, "R5", "sclk pulses per frame", falls, 16);
        check(min_hi >= SCK_HI, "R5", "sclk high phase", min_hi, SCK_HI);
        check(min_lo >= SCK_LO, "R5", "sclk low phase", min_lo, SCK_LO);
        check(last_wait >= CONV_WAIT, "R4", "conversion wait", last_wait, CONV_WAIT);
    endtask

    task automatic t_reset_state();
        check(cv_s === 1'b1, "R1", "convst after reset", int'(cv_s), 1);
        check(sk_s === 1'b0, "R1", "sclk after reset", int'(sk_s), 0);
        check(busy_s === 1'b0 && val_s === 1'b0, "R1", "busy/valid after reset",
              int'({busy_s, val_s}), 0);
        check(res_s === 16'h0 && err_s === 1'b0, "R1", "result/err after reset", int'(res_s), 0);
    endtask

    task automatic t_conv(input logic [11:0] s, input logic [3:0] p);
        smp = s; pad_v = p;
        pulse_start();
        check(busy_s === 1'b1, "R2", "busy after start", int'(busy_s), 1);
        wait_valid();
        check_result(s, p);
        check(last_low == CNV_LOW, "R3", "convst low width", last_low, CNV_LOW);
        @(negedge clk);
        check(val_s === 1'b0, "R10", "strobe one cycle", int'(val_s), 0);
        check(res_s === {{4{s[11]}}, s}, "R10", "result held", int'(res_s), int'({{4{s[11]}}, s}));
        repeat (ACQ + 10) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int cf0, nv0;
        cf0 = n_cv_fall; nv0 = n_valid;
        smp = 12'h3C5; pad_v = 4'h0;
        pulse_start();
        repeat (100) @(negedge clk);
        check(busy_s === 1'b1, "R2", "busy mid cycle", int'(busy_s), 1);
        start = 1'b1; repeat (3) @(negedge clk); start = 1'b0;
        repeat (1700) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_valid();
        check_result(12'h3C5, 4'h0);
        repeat (60) @(negedge clk);
        check(n_cv_fall - cf0 == 1, "R2", "one convst pulse while busy", n_cv_fall - cf0, 1);
        check(n_valid - nv0 == 1, "R2", "one strobe while busy", n_valid - nv0, 1);
        check(busy_s === 1'b0 && cv_s === 1'b1, "R2", "ignored start not queued",
              int'({busy_s, cv_s}), 1);
        repeat (ACQ) @(negedge clk);
    endtask

    task automatic t_back_to_back();
        smp = 12'h6E1; pad_v = 4'h0;
        pulse_start();
        wait_valid();
        check_result(12'h6E1, 4'h0);
        smp = 12'h9B2;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_valid();
        check_result(12'h9B2, 4'h0);
        check(last_gap >= ACQ, "R9", "acquisition gap", last_gap, ACQ);
        check(last_low > CNV_LOW, "R3", "low stretched by acquisition", last_low, CNV_LOW + 1);
        repeat (ACQ + 10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_conv(12'h000, 4'h0);
        t_conv(12'hFFF, 4'h0);
        t_conv(12'h800, 4'h0);
        t_conv(12'h7FF, 4'h0);
        t_conv(12'h5A3, 4'h0);
        t_conv(12'h123, 4'h8);
        t_conv(12'h456, 4'h1);
        t_conv(12'h123, 4'h0);
        t_busy_ignore();
        t_back_to_back();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule